// File: doc/BRIEF.md
# Byte-Addressed GPIO Pin Controller

A register block that manages 36 general-purpose pins over a byte-wide register interface. Every pin has one control byte. Software owns two of its bits, output enable and output data. Hardware owns a third, the sensed level. A software write merges the two kinds of bit by a fixed rule: when the written byte enables the output, the sensed bit loops back from the data bit; otherwise it keeps its previous value.

External logic reports pin input levels through a strobe and level pair per pin. Each strobe rewrites only the sensed bit of that pin. A strobe on a pin that is configured as an output sets a sticky error flag.

Two pins have fixed interrupt roles:
- Pin 1 drives an interrupt that is active while its sensed level is low.
- Pin 9 drives an interrupt that is active while its sensed level is high. A non-maskable-interrupt request pulses pin 9 high for exactly one cycle and then low.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: Pin n's control byte is read at byte offset 8+n (n = 0..35). The read data is combinational in the current address.
- R2: Offsets 0 to 7 are eight read-only level registers that read 0x00. Writes to them change no state.
- R3: Offsets 44 and above read 0x00, and writes there change no state.
- R4: A write to a control byte stores bits 7..2 and bit 0 as written. Bit 1 of the written byte is ignored.
- R5: If the written byte has bit 2 (output enable) set, stored bit 1 takes written bit 0. If bit 2 is clear, stored bit 1 keeps its old value.
- R6: When pin_drive[n] is sampled high, only bit 1 of pin n takes pin_level[n], visible one cycle later. When a strobe and a write hit the same pin in one cycle, the strobe decides bit 1.
- R7: A strobe on a pin whose stored bit 2 is set (before that edge) sets err_flag one cycle later. err_flag then stays set until reset.
- R8: irq_level_low is the inverse of bit 1 of pin 1.
- R9: irq_pulse equals bit 1 of pin 9.
- R10: After reset every control byte is 0x00 except pin 1, which is 0x02. irq_level_low, irq_pulse and err_flag are low.
- R11: nmi_req sampled while the pulse sequencer is idle sets pin 9 bit 1 on the next cycle and clears it on the cycle after. This gives a one-cycle irq_pulse. A request during the high cycle is ignored. During these two edges the sequencer overrides strobes and writes to pin 9 bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset into the 0x30-byte window |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_drive | input | 36 | Per-pin input-level update strobe |
| pin_level | input | 36 | Per-pin input level applied with the strobe |
| nmi_req | input | 1 | Non-maskable-interrupt pulse request |
| irq_level_low | output | 1 | Pin 1 interrupt, active while its level is low |
| irq_pulse | output | 1 | Pin 9 interrupt, active while its level is high |
| err_flag | output | 1 | Sticky flag for a strobe onto an output-enabled pin |

## Verification
Read data follows bus_addr in the same cycle, so the bench samples it a few nanoseconds after changing the address. Writes, strobes and the error flag take effect at the next rising edge. The bench therefore drives each of them on a falling edge and checks on the following falling edge. The pulse sequencer has a two-edge latency: after a request is sampled, irq_pulse is checked high one falling edge later and low on the next two. That window shows both the single pulse and that a request held during the pulse is ignored.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int OE_BIT  = 2;
  localparam int LVL_BIT = 1;
  localparam int DAT_BIT = 0;

  typedef logic [7:0] ctrl_byte_t;

  typedef enum logic {NMI_IDLE = 1'b0, NMI_HIGH = 1'b1} nmi_state_e;

  // Software write merge: sensed bit loops back from data when output enabled
  function automatic ctrl_byte_t merge_sw_write(ctrl_byte_t old_b, ctrl_byte_t wr_b);
    ctrl_byte_t r;
    r = wr_b;
    r[LVL_BIT] = wr_b[OE_BIT] ? wr_b[DAT_BIT] : old_b[LVL_BIT];
    return r;
  endfunction

  // Hardware level merge: only the sensed bit moves
  function automatic ctrl_byte_t merge_hw_level(ctrl_byte_t cur_b, logic lvl);
    ctrl_byte_t r;
    r = cur_b;
    r[LVL_BIT] = lvl;
    return r;
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
  parameter int NUM_PINS  = 36,
  parameter int NUM_LEVEL = 8,
  parameter int ADDR_W    = 6
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  output logic                in_pin,
  output logic [ADDR_W-1:0]   pin_off,
  output logic [NUM_PINS-1:0] wr_hit
);
  localparam logic [ADDR_W-1:0] PIN_BASE = ADDR_W'(NUM_LEVEL);
  localparam logic [ADDR_W-1:0] PIN_END  = ADDR_W'(NUM_LEVEL + NUM_PINS);

  assign in_pin  = (addr >= PIN_BASE) && (addr < PIN_END);
  assign pin_off = addr - PIN_BASE;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_hit
    assign wr_hit[i] = we && in_pin && (pin_off == ADDR_W'(i));
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pin_pkg::*;
#(
  parameter ctrl_byte_t RESET_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_we,
  input  ctrl_byte_t sw_data,
  input  logic       hw_drive,
  input  logic       hw_level,
  input  logic       force_en,
  input  logic       force_level,
  output ctrl_byte_t ctrl_q,
  output logic       conflict
);
  ctrl_byte_t ctrl_nxt;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (sw_we)    ctrl_nxt = merge_sw_write(ctrl_q, sw_data);
    if (hw_drive) ctrl_nxt = merge_hw_level(ctrl_nxt, hw_level);
    if (force_en) ctrl_nxt = merge_hw_level(ctrl_nxt, force_level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= RESET_VAL;
    else        ctrl_q <= ctrl_nxt;
  end

  assign conflict = hw_drive && ctrl_q[OE_BIT];
endmodule

// File: rtl/gpio_nmi_seq.sv
module gpio_nmi_seq
  import gpio_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic force_en,
  output logic force_level,
  output logic idle
);
  nmi_state_e state_q;

  assign idle        = (state_q == NMI_IDLE);
  assign force_en    = (idle && req) || (state_q == NMI_HIGH);
  assign force_level = idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             state_q <= NMI_IDLE;
    else if (idle && req)   state_q <= NMI_HIGH;
    else                    state_q <= NMI_IDLE;
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int NUM_PINS   = 36,
  parameter int NUM_LEVEL  = 8,
  parameter int ADDR_W     = 6,
  parameter int LOWIRQ_PIN = 1,
  parameter int PULSE_PIN  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [NUM_PINS-1:0] pin_drive,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic                nmi_req,
  output logic                irq_level_low,
  output logic                irq_pulse,
  output logic                err_flag
);
  localparam int FLAT_W = NUM_PINS * 8;

  logic                in_pin;
  logic [ADDR_W-1:0]   pin_off;
  logic [NUM_PINS-1:0] wr_hit;
  logic [NUM_PINS-1:0] conflict_vec;
  logic [NUM_PINS-1:0] force_en_vec;
  logic                nmi_force_en;
  logic                nmi_force_level;
  logic                nmi_idle;
  logic                err_q;
  ctrl_byte_t          ctrl_q [NUM_PINS];
  logic [FLAT_W-1:0]   ctrl_flat;

  gpio_addr_decode #(
    .NUM_PINS (NUM_PINS),
    .NUM_LEVEL(NUM_LEVEL),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr   (bus_addr),
    .we     (bus_we),
    .in_pin (in_pin),
    .pin_off(pin_off),
    .wr_hit (wr_hit)
  );

  gpio_nmi_seq u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (nmi_req),
    .force_en   (nmi_force_en),
    .force_level(nmi_force_level),
    .idle       (nmi_idle)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam ctrl_byte_t RV = (i == LOWIRQ_PIN) ? ctrl_byte_t'(1 << LVL_BIT) : '0;
    assign force_en_vec[i] = (i == PULSE_PIN) ? nmi_force_en : 1'b0;

    gpio_pin_cell #(.RESET_VAL(RV)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_we      (wr_hit[i]),
      .sw_data    (bus_wdata),
      .hw_drive   (pin_drive[i]),
      .hw_level   (pin_level[i]),
      .force_en   (force_en_vec[i]),
      .force_level(nmi_force_level),
      .ctrl_q     (ctrl_q[i]),
      .conflict   (conflict_vec[i])
    );
    assign ctrl_flat[i*8 +: 8] = ctrl_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (|conflict_vec);
  end

  always_comb begin
    bus_rdata = '0;
    if (in_pin) bus_rdata = ctrl_q[pin_off];
  end

  assign irq_level_low = ~ctrl_q[LOWIRQ_PIN][LVL_BIT];
  assign irq_pulse     = ctrl_q[PULSE_PIN][LVL_BIT];
  assign err_flag      = err_q;
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk #(
  parameter int NUM_PINS   = 36,
  parameter int NUM_LEVEL  = 8,
  parameter int ADDR_W     = 6,
  parameter int LOWIRQ_PIN = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic                  wr_oe,
  input logic                  wr_d0,
  input logic [NUM_PINS-1:0]   pin_drive,
  input logic                  nmi_req,
  input logic                  nmi_idle,
  input logic [NUM_PINS-1:0]   wr_hit,
  input logic [NUM_PINS*8-1:0] ctrl_flat,
  input logic                  irq_level_low,
  input logic                  irq_pulse,
  input logic                  err_flag
);
  logic [NUM_PINS-1:0] oe_vec;
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_oe
    assign oe_vec[i] = ctrl_flat[i*8 + 2];
  end

  assert_reset_state_R10: assert property (@(posedge clk)
    !rst_n |=> (!irq_level_low && !irq_pulse && !err_flag));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_err_on_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pin_drive & oe_vec)) |=> err_flag);

  assert_level_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr < ADDR_W'(NUM_LEVEL)) && !(|pin_drive) && !nmi_req && nmi_idle)
    |=> $stable(ctrl_flat));

  assert_nmi_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && nmi_idle) |=> (irq_pulse ##1 !irq_pulse));

  assert_loopback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[LOWIRQ_PIN] && wr_oe && !pin_drive[LOWIRQ_PIN])
    |=> (irq_level_low == !$past(wr_d0)));

  assert_irq_low_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_level_low) |-> $past(wr_hit[LOWIRQ_PIN] || pin_drive[LOWIRQ_PIN]));
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(
  .NUM_PINS  (NUM_PINS),
  .NUM_LEVEL (NUM_LEVEL),
  .ADDR_W    (ADDR_W),
  .LOWIRQ_PIN(LOWIRQ_PIN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .wr_oe        (bus_wdata[2]),
  .wr_d0        (bus_wdata[0]),
  .pin_drive    (pin_drive),
  .nmi_req      (nmi_req),
  .nmi_idle     (nmi_idle),
  .wr_hit       (wr_hit),
  .ctrl_flat    (ctrl_flat),
  .irq_level_low(irq_level_low),
  .irq_pulse    (irq_pulse),
  .err_flag     (err_flag)
);

// File: tb/gpio_pin_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_tb;
  localparam int NP = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pin_drive = '0;
  logic [NP-1:0] pin_level = '0;
  logic          nmi_req = 1'b0;
  logic          irq_level_low, irq_pulse, err_flag;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [7:0] model [NP];

  always #10 clk = ~clk;

  gpio_pin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_drive(pin_drive),
    .pin_level(pin_level), .nmi_req(nmi_req), .irq_level_low(irq_level_low),
    .irq_pulse(irq_pulse), .err_flag(err_flag)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // expected stored byte after a software write (R4/R5), written independently
  function automatic logic [7:0] sw_expect(logic [7:0] old_b, logic [7:0] w);
    logic s;
    s = (w & 8'h04) != 0 ? w[0] : old_b[1];
    return {w[7:2], s, w[0]};
  endfunction

  task automatic bus_write(int addr, logic [7:0] d);
    @(negedge clk);
    bus_addr = 6'(addr); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (addr >= 8 && addr < 8 + NP) model[addr-8] = sw_expect(model[addr-8], d);
  endtask

  task automatic bus_read(int addr, output logic [7:0] d);
    bus_addr = 6'(addr);
    #2 d = bus_rdata;
  endtask

  task automatic check_pin(string req, int n);
    logic [7:0] d;
    bus_read(8 + n, d);
    check(req, d, model[n]);
  endtask

  task automatic check_all_pins(string req);
    for (int n = 0; n < NP; n++) check_pin(req, n);
  endtask

  task automatic drive_pin(int n, logic lvl);
    @(negedge clk);
    pin_drive[n] = 1'b1; pin_level[n] = lvl;
    @(negedge clk);
    pin_drive[n] = 1'b0;
    model[n][1] = lvl;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int n = 0; n < NP; n++) model[n] = (n == 1) ? 8'h02 : 8'h00;
    check_all_pins("R10 reset byte");
    check("R10 irq_level_low", {7'b0, irq_level_low}, 8'h00);
    check("R10 irq_pulse", {7'b0, irq_pulse}, 8'h00);
    check("R10 err_flag", {7'b0, err_flag}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      bus_read(a, d); check("R2 level reg read", d, 8'h00);
    end
  endtask

  task automatic t_write_rules;
    bus_write(8 + 5, 8'hFF); check_pin("R1 R4 R5 oe set, data 1", 5);
    check("R5 loopback value", model[5], 8'hFF);
    bus_write(8 + 5, 8'hFA); check_pin("R5 oe clear keeps level", 5);
    check("R5 expected 0xFA", model[5], 8'hFA);
    bus_write(8 + 5, 8'h06); check_pin("R4 written bit1 ignored", 5);
    check("R4 expected 0x04", model[5], 8'h04);
    bus_write(8 + 5, 8'h01); check_pin("R5 keeps level 0", 5);
    bus_write(8 + 0, 8'hA5); check_pin("R1 pin 0", 0);
    bus_write(8 + 35, 8'h05); check_pin("R1 pin 35", 35);
    check("R5 expected 0x07", model[35], 8'h07);
  endtask

  task automatic t_windows;
    logic [7:0] d;
    bus_write(3, 8'hAA);
    bus_read(3, d); check("R2 level write dropped", d, 8'h00);
    bus_write(44, 8'h55); bus_write(47, 8'h33);
    bus_read(44, d); check("R3 offset 44 reads 0", d, 8'h00);
    bus_read(47, d); check("R3 offset 47 reads 0", d, 8'h00);
    bus_read(63, d); check("R3 offset 63 reads 0", d, 8'h00);
    check_all_pins("R2 R3 no pin changed");
  endtask

  task automatic t_drive;
    bus_write(8 + 20, 8'hF0);
    drive_pin(20, 1'b1);
    check_pin("R6 strobe sets level only", 20);
    check("R6 expected 0xF2", model[20], 8'hF2);
    @(negedge clk);
    bus_addr = 6'(8 + 20); bus_wdata = 8'h05; bus_we = 1'b1;
    pin_drive[20] = 1'b1; pin_level[20] = 1'b0;
    @(negedge clk);
    bus_we = 1'b0; pin_drive[20] = 1'b0;
    model[20] = 8'h05 & 8'hFD;
    check_pin("R6 strobe wins over write", 20);
    check("R7 no error when oe set in same cycle", {7'b0, err_flag}, 8'h00);
  endtask

  task automatic t_irq_low;
    bus_write(8 + 1, 8'h04);
    check("R8 R5 output low asserts irq", {7'b0, irq_level_low}, 8'h01);
    bus_write(8 + 1, 8'h05);
    check("R8 output high releases irq", {7'b0, irq_level_low}, 8'h00);
    bus_write(8 + 1, 8'h00);
    check("R5 R8 oe clear keeps level high", {7'b0, irq_level_low}, 8'h00);
    drive_pin(1, 1'b0);
    check("R8 R6 input low asserts irq", {7'b0, irq_level_low}, 8'h01);
    drive_pin(1, 1'b1);
    check("R8 input high releases irq", {7'b0, irq_level_low}, 8'h00);
  endtask

  task automatic t_irq9;
    drive_pin(9, 1'b1);
    check("R9 level high asserts irq", {7'b0, irq_pulse}, 8'h01);
    drive_pin(9, 1'b0);
    check("R9 level low releases irq", {7'b0, irq_pulse}, 8'h00);
  endtask

  task automatic t_nmi;
    @(negedge clk);
    nmi_req = 1'b1;
    @(negedge clk);
    check("R11 pulse high one edge after request", {7'b0, irq_pulse}, 8'h01);
    @(negedge clk);
    nmi_req = 1'b0;
    check("R11 pulse low on second edge", {7'b0, irq_pulse}, 8'h00);
    @(negedge clk);
    check("R11 request in high cycle ignored", {7'b0, irq_pulse}, 8'h00);
    @(negedge clk);
    nmi_req = 1'b1; pin_drive[9] = 1'b1; pin_level[9] = 1'b0;
    @(negedge clk);
    nmi_req = 1'b0; pin_drive[9] = 1'b0;
    check("R11 request overrides strobe", {7'b0, irq_pulse}, 8'h01);
    @(negedge clk);
    check("R11 second pulse ends", {7'b0, irq_pulse}, 8'h00);
    model[9][1] = 1'b0;
    check_pin("R11 pin 9 byte after pulse", 9);
  endtask

  task automatic t_err;
    check("R7 err clear before conflict", {7'b0, err_flag}, 8'h00);
    drive_pin(20, 1'b1);
    check("R7 strobe on output pin sets err", {7'b0, err_flag}, 8'h01);
    bus_write(8 + 20, 8'h00);
    drive_pin(20, 1'b0);
    check("R7 err stays set", {7'b0, err_flag}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_rules();
    t_windows();
    t_drive();
    t_irq_low();
    t_irq9();
    t_nmi();
    t_err();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule